// File: doc/BRIEF.md
# Translation Buffer Demap Engine

This block keeps a fully associative set of address-translation entries and removes entries on request. Each entry holds a virtual tag, a context number, a valid flag, a global flag and a 2-bit page-size code. Two context registers, one primary and one secondary, are written through a small context port. Entries are loaded through a plain indexed write port. A registered readback port returns any entry's fields and valid flag, so the surrounding logic can inspect the buffer.

A demap request carries one address word, which is the access address and not a data value. Bit 6 of that word picks the kind of removal. Bits 5:4 pick the context to compare against. Once a request is accepted, a scanner walks the entries one per cycle. It reads the stored fields from a synchronous RAM and evaluates each entry against the request. An entry that matches has only its valid flag cleared. While the scan runs, busy is high. A single-cycle done pulse marks the cycle in which busy falls.

Top module: `tlb_demap_engine`

## Requirements
- R1: After reset, every entry reads back invalid, both context registers read zero, and busy and done are low.
- R2: When idle, an entry write stores the tag, context, global flag, page-size code and valid flag at the given index. A readback of that index presents them one clock after the index is applied.
- R3: A demap request is accepted only when busy is low. Busy then stays high for exactly ENTRIES+1 cycles. Done is high for exactly one cycle, the first cycle with busy low. A request held high during the scan does not start a second scan.
- R4: Address bit 6 selects the operation: 0 removes entries by page and 1 removes entries by context.
- R5: Address bits 5:4 select the comparison context: 0 selects the primary register, 1 selects the secondary register, and 2 selects the nucleus context, which is the value zero. The register values are captured when the request is accepted.
- R6: Context code 3 is reserved. The scan runs and done pulses, but no entry is invalidated.
- R7: A page removal compares the request address with an entry's tag only above bit 13+3*psize, where psize is that entry's page-size code (0..3). All lower bits are ignored.
- R8: A page removal invalidates a valid entry whose masked tag matches only if the entry is global or its context equals the selected context.
- R9: A context removal invalidates every valid non-global entry whose context equals the selected context. Global entries survive it.
- R10: Invalidation clears the valid flag alone. The tag, context, global flag and page-size code read back unchanged.
- R11: Entry writes and context-register writes presented while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_wr_en | input | 1 | Context register write strobe |
| ctx_wr_sel | input | 1 | 0 writes the primary register, 1 writes the secondary register |
| ctx_wr_data | input | CTX_W | Context value to write |
| ent_wr_en | input | 1 | Entry write strobe |
| ent_wr_idx | input | log2(ENTRIES) | Entry index to write |
| ent_wr_tag | input | VA_W | Virtual tag to store |
| ent_wr_ctx | input | CTX_W | Entry context to store |
| ent_wr_global | input | 1 | Entry global flag to store |
| ent_wr_psize | input | 2 | Entry page-size code to store |
| ent_wr_valid | input | 1 | Entry valid flag to store |
| rd_idx | input | log2(ENTRIES) | Readback index |
| rd_valid | output | 1 | Valid flag of the read entry (registered) |
| rd_tag | output | VA_W | Tag of the read entry (registered) |
| rd_ctx | output | CTX_W | Context of the read entry (registered) |
| rd_global | output | 1 | Global flag of the read entry (registered) |
| rd_psize | output | 2 | Page-size code of the read entry (registered) |
| pri_ctx | output | CTX_W | Primary context register |
| sec_ctx | output | CTX_W | Secondary context register |
| dmp_req | input | 1 | Demap request |
| dmp_addr | input | VA_W | Demap address word (operation in bit 6, context code in bits 5:4) |
| dmp_busy | output | 1 | Scan in progress |
| dmp_done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with ENTRIES=16, VA_W=32 and CTX_W=4. With 16 entries, every scan can be followed by a full readback of the buffer. The entry pattern cycles through all four page-size codes, mixes global and non-global entries, and includes invalid entries and four context values. The bench then sweeps both operations, all four context codes and several target addresses. Each address lies either inside the tagged region or outside it, so every combination of mask width, global flag and context selection appears against a freshly loaded buffer.

// File: rtl/tlb_demap_pkg.sv
package tlb_demap_pkg;
  localparam int OP_BIT = 6;
  localparam int SEL_LO = 4;

  typedef enum logic {
    DM_PAGE = 1'b0,
    DM_CTX  = 1'b1
  } demap_op_e;

  typedef enum logic [1:0] {
    CSEL_PRI = 2'd0,
    CSEL_SEC = 2'd1,
    CSEL_NUC = 2'd2,
    CSEL_RSV = 2'd3
  } ctx_sel_e;
endpackage

// File: rtl/tlb_field_ram.sv
module tlb_field_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata_a <= mem[raddr_a];
  end

  always_ff @(posedge clk) begin
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/tlb_match_unit.sv
module tlb_match_unit
  import tlb_demap_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int CTX_W      = 13,
  parameter int PAGE_SHIFT = 13,
  parameter int PSZ_STEP   = 3
) (
  input  logic             ent_valid,
  input  logic [VA_W-1:0]  ent_tag,
  input  logic [CTX_W-1:0] ent_ctx,
  input  logic             ent_global,
  input  logic [1:0]       ent_psize,
  input  logic [VA_W-1:0]  req_addr,
  input  demap_op_e        req_op,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic             req_kill,
  output logic             hit
);
  localparam logic [VA_W-1:0] ALL_ONES = {VA_W{1'b1}};

  logic [7:0]      shamt;
  logic [VA_W-1:0] mask;
  logic            va_eq;
  logic            ctx_eq;

  always_comb begin
    shamt  = 8'(PAGE_SHIFT) + 8'(PSZ_STEP) * {6'd0, ent_psize};
    mask   = ALL_ONES << shamt;
    va_eq  = ((req_addr ^ ent_tag) & mask) == '0;
    ctx_eq = (ent_ctx == req_ctx);
    hit    = 1'b0;
    if (ent_valid && !req_kill) begin
      if (req_op == DM_CTX) hit = !ent_global && ctx_eq;
      else                  hit = va_eq && (ent_global || ctx_eq);
    end
  end
endmodule

// File: rtl/tlb_demap_scan.sv
module tlb_demap_scan #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] rd_ptr,
  output logic             eval_vld,
  output logic [IDX_W-1:0] eval_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             busy_q, issue_q, eval_vld_q, done_q;
  logic [IDX_W-1:0] ptr_q, eval_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      issue_q    <= 1'b0;
      eval_vld_q <= 1'b0;
      done_q     <= 1'b0;
      ptr_q      <= '0;
      eval_idx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        busy_q  <= 1'b1;
        issue_q <= 1'b1;
        ptr_q   <= '0;
      end
      if (issue_q) begin
        eval_vld_q <= 1'b1;
        eval_idx_q <= ptr_q;
        ptr_q      <= ptr_q + 1'b1;
        if (ptr_q == LAST) issue_q <= 1'b0;
      end else begin
        eval_vld_q <= 1'b0;
      end
      if (eval_vld_q && eval_idx_q == LAST) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rd_ptr   = ptr_q;
  assign eval_vld = eval_vld_q;
  assign eval_idx = eval_idx_q;
endmodule

// File: rtl/tlb_demap_engine.sv
module tlb_demap_engine
  import tlb_demap_pkg::*;
#(
  parameter int ENTRIES    = 64,
  parameter int VA_W       = 48,
  parameter int CTX_W      = 13,
  parameter int PAGE_SHIFT = 13,
  parameter int PSZ_STEP   = 3,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctx_wr_en,
  input  logic             ctx_wr_sel,
  input  logic [CTX_W-1:0] ctx_wr_data,
  input  logic             ent_wr_en,
  input  logic [IDX_W-1:0] ent_wr_idx,
  input  logic [VA_W-1:0]  ent_wr_tag,
  input  logic [CTX_W-1:0] ent_wr_ctx,
  input  logic             ent_wr_global,
  input  logic [1:0]       ent_wr_psize,
  input  logic             ent_wr_valid,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [VA_W-1:0]  rd_tag,
  output logic [CTX_W-1:0] rd_ctx,
  output logic             rd_global,
  output logic [1:0]       rd_psize,
  output logic [CTX_W-1:0] pri_ctx,
  output logic [CTX_W-1:0] sec_ctx,
  input  logic             dmp_req,
  input  logic [VA_W-1:0]  dmp_addr,
  output logic             dmp_busy,
  output logic             dmp_done
);
  localparam int FW = VA_W + CTX_W + 3;

  logic [ENTRIES-1:0] vld_q;
  logic [CTX_W-1:0]   pri_q, sec_q;
  logic               accept;
  logic               wr_ok;

  logic [VA_W-1:0]    req_addr_q;
  demap_op_e          req_op_q;
  logic [CTX_W-1:0]   req_ctx_q;
  logic               req_kill_q;

  logic [IDX_W-1:0]   scan_ptr, eval_idx;
  logic               eval_vld, hit;
  logic [FW-1:0]      wr_word, scan_word, rb_word;

  assign accept = dmp_req && !dmp_busy;
  assign wr_ok  = !dmp_busy;

  tlb_demap_scan #(.ENTRIES(ENTRIES)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .busy     (dmp_busy),
    .done     (dmp_done),
    .rd_ptr   (scan_ptr),
    .eval_vld (eval_vld),
    .eval_idx (eval_idx)
  );

  assign wr_word = {ent_wr_tag, ent_wr_ctx, ent_wr_global, ent_wr_psize};

  tlb_field_ram #(.DEPTH(ENTRIES), .DW(FW)) u_ram (
    .clk     (clk),
    .we      (ent_wr_en && wr_ok),
    .waddr   (ent_wr_idx),
    .wdata   (wr_word),
    .raddr_a (scan_ptr),
    .rdata_a (scan_word),
    .raddr_b (rd_idx),
    .rdata_b (rb_word)
  );

  tlb_match_unit #(
    .VA_W(VA_W), .CTX_W(CTX_W), .PAGE_SHIFT(PAGE_SHIFT), .PSZ_STEP(PSZ_STEP)
  ) u_match (
    .ent_valid  (vld_q[eval_idx]),
    .ent_tag    (scan_word[FW-1 -: VA_W]),
    .ent_ctx    (scan_word[CTX_W+2:3]),
    .ent_global (scan_word[2]),
    .ent_psize  (scan_word[1:0]),
    .req_addr   (req_addr_q),
    .req_op     (req_op_q),
    .req_ctx    (req_ctx_q),
    .req_kill   (req_kill_q),
    .hit        (hit)
  );

  // request capture: operation, context snapshot, reserved-code kill
  always_ff @(posedge clk) begin
    if (rst) begin
      req_addr_q <= '0;
      req_op_q   <= DM_PAGE;
      req_ctx_q  <= '0;
      req_kill_q <= 1'b0;
    end else if (accept) begin
      req_addr_q <= dmp_addr;
      req_op_q   <= demap_op_e'(dmp_addr[OP_BIT]);
      req_kill_q <= 1'b0;
      case (ctx_sel_e'(dmp_addr[SEL_LO +: 2]))
        CSEL_PRI: req_ctx_q <= pri_q;
        CSEL_SEC: req_ctx_q <= sec_q;
        CSEL_NUC: req_ctx_q <= '0;
        default: begin
          req_ctx_q  <= '0;
          req_kill_q <= 1'b1;
        end
      endcase
    end
  end

  // context registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pri_q <= '0;
      sec_q <= '0;
    end else if (ctx_wr_en && wr_ok) begin
      if (ctx_wr_sel) sec_q <= ctx_wr_data;
      else            pri_q <= ctx_wr_data;
    end
  end

  // valid flags: set by the write port, cleared by the scanner
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (ent_wr_en && wr_ok) vld_q[ent_wr_idx] <= ent_wr_valid;
      if (eval_vld && hit)    vld_q[eval_idx]   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= vld_q[rd_idx];
  end

  assign rd_tag    = rb_word[FW-1 -: VA_W];
  assign rd_ctx    = rb_word[CTX_W+2:3];
  assign rd_global = rb_word[2];
  assign rd_psize  = rb_word[1:0];
  assign pri_ctx   = pri_q;
  assign sec_ctx   = sec_q;
endmodule

// File: rtl/tlb_demap_checker.sv
module tlb_demap_checker #(
  parameter int ENTRIES = 64,
  parameter int CTX_W   = 13
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               done,
  input logic [ENTRIES-1:0] vld,
  input logic [CTX_W-1:0]   pri,
  input logic [CTX_W-1:0]   sec
);
  localparam int CW = $clog2(ENTRIES + 2) + 1;
  localparam logic [CW-1:0] SCAN_LEN = CW'(ENTRIES + 1);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_scan_length_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> busy_cnt == SCAN_LEN);

  assert_scan_bounded_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> busy_cnt < SCAN_LEN);

  assert_no_valid_set_busy_R11: assert property (@(posedge clk) disable iff (rst)
    busy |=> ((vld & ~$past(vld)) == '0));

  assert_ctx_frozen_busy_R11: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(pri) && $stable(sec)));
endmodule

bind tlb_demap_engine tlb_demap_checker #(.ENTRIES(ENTRIES), .CTX_W(CTX_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .busy (dmp_busy),
  .done (dmp_done),
  .vld  (vld_q),
  .pri  (pri_ctx),
  .sec  (sec_ctx)
);

// File: tb/tb_tlb_demap_engine.sv
`timescale 1ns/1ps
module tb_tlb_demap_engine;
  localparam int N  = 16;
  localparam int VA = 32;
  localparam int CW = 4;
  localparam int IW = 4;
  localparam logic [CW-1:0] PRI = 4'd5;
  localparam logic [CW-1:0] SEC = 4'd9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic          ctx_wr_en = 0, ctx_wr_sel = 0;
  logic [CW-1:0] ctx_wr_data = '0;
  logic          ent_wr_en = 0;
  logic [IW-1:0] ent_wr_idx = '0;
  logic [VA-1:0] ent_wr_tag = '0;
  logic [CW-1:0] ent_wr_ctx = '0;
  logic          ent_wr_global = 0, ent_wr_valid = 0;
  logic [1:0]    ent_wr_psize = '0;
  logic [IW-1:0] rd_idx = '0;
  logic          rd_valid, rd_global;
  logic [VA-1:0] rd_tag;
  logic [CW-1:0] rd_ctx, pri_ctx, sec_ctx;
  logic [1:0]    rd_psize;
  logic          dmp_req = 0;
  logic [VA-1:0] dmp_addr = '0;
  logic          dmp_busy, dmp_done;

  int n_tests = 0;
  int n_fail  = 0;
  bit m_vld [N];

  always #2.5 clk = ~clk;

  tlb_demap_engine #(.ENTRIES(N), .VA_W(VA), .CTX_W(CW)) dut (
    .clk(clk), .rst(rst),
    .ctx_wr_en(ctx_wr_en), .ctx_wr_sel(ctx_wr_sel), .ctx_wr_data(ctx_wr_data),
    .ent_wr_en(ent_wr_en), .ent_wr_idx(ent_wr_idx), .ent_wr_tag(ent_wr_tag),
    .ent_wr_ctx(ent_wr_ctx), .ent_wr_global(ent_wr_global),
    .ent_wr_psize(ent_wr_psize), .ent_wr_valid(ent_wr_valid),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_ctx(rd_ctx),
    .rd_global(rd_global), .rd_psize(rd_psize),
    .pri_ctx(pri_ctx), .sec_ctx(sec_ctx),
    .dmp_req(dmp_req), .dmp_addr(dmp_addr), .dmp_busy(dmp_busy), .dmp_done(dmp_done)
  );

  function automatic logic [VA-1:0] f_tag(int i);
    return 32'h4A00_0000 + VA'(i) * 32'h0000_6000;
  endfunction
  function automatic logic [CW-1:0] f_ctx(int i);
    case (i % 4)
      0: return 4'd0;
      1: return PRI;
      2: return SEC;
      default: return 4'd7;
    endcase
  endfunction
  function automatic bit f_glb(int i);
    return (i % 5) == 1;
  endfunction
  function automatic logic [1:0] f_psz(int i);
    return 2'((i >> 2) & 3);
  endfunction
  function automatic bit f_vld(int i);
    return (i % 7) != 3;
  endfunction

  function automatic bit exp_hit(int i, logic [VA-1:0] a);
    logic [CW-1:0] sel;
    logic [VA-1:0] mask;
    int code;
    code = int'(a[5:4]);
    if (code == 3 || !m_vld[i]) return 1'b0;
    sel = (code == 0) ? PRI : (code == 1) ? SEC : 4'd0;
    if (a[6]) return !f_glb(i) && (f_ctx(i) == sel);
    mask = 32'hFFFF_FFFF << (13 + 3 * int'(f_psz(i)));
    return (((a ^ f_tag(i)) & mask) == '0) && (f_glb(i) || f_ctx(i) == sel);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_ent(int i, logic [VA-1:0] t, logic [CW-1:0] c, bit g,
                        logic [1:0] p, bit v);
    @(negedge clk);
    ent_wr_en = 1; ent_wr_idx = IW'(i); ent_wr_tag = t; ent_wr_ctx = c;
    ent_wr_global = g; ent_wr_psize = p; ent_wr_valid = v;
    @(negedge clk);
    ent_wr_en = 0;
  endtask

  task automatic wr_ctx(bit s, logic [CW-1:0] d);
    @(negedge clk);
    ctx_wr_en = 1; ctx_wr_sel = s; ctx_wr_data = d;
    @(negedge clk);
    ctx_wr_en = 0;
  endtask

  task automatic load_all();
    for (int i = 0; i < N; i++) begin
      m_vld[i] = f_vld(i);
      wr_ent(i, f_tag(i), f_ctx(i), f_glb(i), f_psz(i), f_vld(i));
    end
  endtask

  task automatic read_ent(int i);
    @(negedge clk);
    rd_idx = IW'(i);
    @(negedge clk);
  endtask

  // R3: issue one request, hold it through the scan, count busy cycles
  task automatic run_demap(logic [VA-1:0] a, bit inject);
    int cnt;
    @(negedge clk);
    dmp_addr = a; dmp_req = 1;
    @(negedge clk);
    dmp_addr = 32'h0000_0000;
    cnt = 0;
    while (dmp_busy && cnt < 100) begin
      cnt++;
      if (inject && cnt == 1) begin
        ent_wr_en = 1; ent_wr_idx = '0; ent_wr_tag = 32'h1111_1000;
        ent_wr_ctx = 4'd3; ent_wr_global = 1; ent_wr_psize = 2'd3; ent_wr_valid = 1;
        ctx_wr_en = 1; ctx_wr_sel = 0; ctx_wr_data = 4'd15;
      end
      if (cnt == 2) begin
        ent_wr_en = 0; ctx_wr_en = 0;
      end
      @(negedge clk);
    end
    chk(cnt == N + 1, "R3", "busy cycles", cnt, N + 1);
    chk(dmp_done == 1'b1, "R3", "done after scan", dmp_done, 1);
    dmp_req = 0;
    @(negedge clk);
    chk(!dmp_done && !dmp_busy, "R3", "single done, no restart",
        {dmp_done, dmp_busy}, 0);
  endtask

  task automatic sweep_one(logic [VA-1:0] a);
    bit   exp_v [N];
    string lbl;
    load_all();
    for (int i = 0; i < N; i++) exp_v[i] = m_vld[i] && !exp_hit(i, a);
    run_demap(a, 1'b0);
    for (int i = 0; i < N; i++) begin
      m_vld[i] = exp_v[i];
      if (a[5:4] == 2'd3)      lbl = "R6";
      else if (a[6])           lbl = "R4 R9";
      else if (f_psz(i) != 0)  lbl = "R4 R7";
      else                     lbl = "R5 R8";
      read_ent(i);
      chk(rd_valid == exp_v[i], lbl, $sformatf("valid e%0d addr %h", i, a),
          rd_valid, exp_v[i]);
      chk(rd_tag == f_tag(i) && rd_ctx == f_ctx(i) && rd_global == f_glb(i)
          && rd_psize == f_psz(i), "R10", $sformatf("fields e%0d", i),
          {rd_tag, rd_ctx, rd_global, rd_psize},
          {f_tag(i), f_ctx(i), f_glb(i), f_psz(i)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [VA-1:0] targets [5];
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(!dmp_busy && !dmp_done, "R1", "busy/done", {dmp_busy, dmp_done}, 0);
    chk(pri_ctx == 0 && sec_ctx == 0, "R1", "contexts", {pri_ctx, sec_ctx}, 0);
    for (int i = 0; i < N; i++) begin
      read_ent(i);
      chk(!rd_valid, "R1", $sformatf("valid e%0d", i), rd_valid, 0);
    end
    // R2
    wr_ent(3, 32'hDEAD_E000, 4'hB, 1'b1, 2'd2, 1'b1);
    read_ent(3);
    chk(rd_valid && rd_tag == 32'hDEAD_E000 && rd_ctx == 4'hB && rd_global
        && rd_psize == 2'd2, "R2", "entry write/readback",
        {rd_valid, rd_tag, rd_ctx, rd_global, rd_psize},
        {1'b1, 32'hDEAD_E000, 4'hB, 1'b1, 2'd2});
    // R5 context registers
    wr_ctx(1'b0, PRI);
    wr_ctx(1'b1, SEC);
    chk(pri_ctx == PRI && sec_ctx == SEC, "R5", "context regs",
        {pri_ctx, sec_ctx}, {PRI, SEC});
    // sweep: operation x context code x target
    targets[0] = f_tag(0);
    targets[1] = f_tag(5);
    targets[2] = f_tag(10);
    targets[3] = f_tag(15);
    targets[4] = 32'h5B00_0000;
    for (int op = 0; op < 2; op++)
      for (int code = 0; code < 4; code++)
        for (int k = 0; k < 5; k++)
          sweep_one((targets[k] & 32'hFFFF_E000) | 32'h0000_1A83
                    | (VA'(op) << 6) | (VA'(code) << 4));
    // R11: writes during a scan are dropped (reserved code, so nothing removed)
    load_all();
    run_demap(32'h0000_0030, 1'b1);
    read_ent(0);
    chk(rd_valid == f_vld(0) && rd_tag == f_tag(0) && rd_ctx == f_ctx(0)
        && rd_global == f_glb(0) && rd_psize == f_psz(0), "R11",
        "entry write while busy", {rd_valid, rd_tag, rd_ctx},
        {f_vld(0), f_tag(0), f_ctx(0)});
    chk(pri_ctx == PRI, "R11", "context write while busy", pri_ctx, PRI);
    for (int i = 0; i < N; i++) begin
      read_ent(i);
      chk(rd_valid == f_vld(i), "R6", $sformatf("reserved code e%0d", i),
          rd_valid, f_vld(i));
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule